// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This block is the codec-side controller that takes the serial audio link through its operating states: held in reset, starting up, running, stopped after a power-down write, and a test state in which every digital output floats. It runs on the master clock. It drives the bit clock by dividing that clock by two, and it produces the enables that gate the bit clock, the divider, the serial data return line and the digital output pads. It also holds the register file in reset for as long as the link reset pin is low.

A frame lasts `FRAME_BITS` bit clocks. A rising edge of SYNC while the link is running restarts the bit count; such an edge is never a wake-up. The register interface sends a one-cycle power-down command. The link keeps running to the end of the last bit of slot 2, then stops. In the stopped state, SYNC held high for at least `WARM_MIN` master-clock cycles and then released restarts the link. Shorter pulses are discarded. If SDATA_OUT is high when RESET is released, the block enters the test state. It leaves that state only through a new cold reset.

Top module: `aclink_pwr_ctl`

## Requirements
- R1: While `rst_pin_n` is low at a clock edge, the block returns to its cold state. From the next cycle on, `regs_rst`=1, `pad_oe`=1, and `bit_clk`, `bit_clk_en`, `div_en` and `sdin_en` are all 0.
- R2: The release edge is the first edge that samples `rst_pin_n` high. If `sdata_out` is low on that edge, `div_en` goes high after it and `regs_rst` goes low. `bit_clk_en` goes high `START_DLY` edges later.
- R3: While `bit_clk_en` is high, `bit_clk` changes value on every master-clock edge, so it runs at half the master clock. It is low on the first running cycle after startup.
- R4: A rising edge of `sync` while running sets the bit position to 0 on that edge. Any SYNC pulse while running, however long, keeps the link running.
- R5: The bit position advances each time a high half of `bit_clk` ends, and it wraps at `FRAME_BITS`. Slot 0 is bits 0 to `SLOT0_BITS`-1. Slots 1 and 2 follow with `SLOT_BITS` bits each, so with the defaults slot 2 ends at bit 55. After a `pd_cmd` pulse, the link stops on the first edge that ends the high half of that last bit: `bit_clk_en`, `div_en` and `sdin_en` fall together. A pulse on that same edge also counts.
- R6: While the link is stopped, `pd_cmd` has no effect, and a SYNC high pulse sampled on fewer than `WARM_MIN` edges leaves the link stopped.
- R7: While the link is stopped, a SYNC high pulse sampled on at least `WARM_MIN` edges starts the link on the edge that samples `sync` low. `div_en` rises then, and `bit_clk_en` follows `START_DLY` edges later.
- R8: A cold reset from the stopped or running state clears any pending power-down. After release, the link runs until a new `pd_cmd`.
- R9: If `sdata_out` is high on the release edge, `pad_oe` goes to 0 and stays 0 until `rst_pin_n` is next low. Meanwhile `bit_clk_en`, `div_en`, `sdin_en` and `regs_rst` stay 0, and `sync` and `pd_cmd` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, twice the bit rate |
| rst_pin_n | input | 1 | Link cold-reset pin, active low, sampled on mclk |
| sync | input | 1 | Frame sync from the controller |
| sdata_out | input | 1 | Controller-to-codec serial data; only its level at reset release is used |
| pd_cmd | input | 1 | One-cycle decoded power-down-link command from the register interface |
| bit_clk | output | 1 | Divided bit clock, low whenever the link is not running |
| bit_clk_en | output | 1 | Bit clock pin running |
| div_en | output | 1 | Clock divider enabled (startup and running) |
| sdin_en | output | 1 | Serial return data line may carry data; low forces it low |
| pad_oe | output | 1 | Global output enable for digital pads; 0 in test state |
| regs_rst | output | 1 | Register file reset, high during cold reset |

## Verification
On every cycle, the assertions check the cold-reset output state, the half-rate toggling of the running bit clock, and that the clock stops only on an end-of-slot-2 event. They also check that a restart out of the stopped state always follows a qualified long SYNC pulse, and that the test state keeps every enable quiet. Only the bench scenarios can show the exact bit count from a SYNC edge to the stop. They also cover the exact boundary between a pulse that is one cycle too short and one that is just long enough, the startup delay in cycles, and that a command issued after slot 2 waits for the following frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [2:0] {
    LK_COLD  = 3'd0,
    LK_START = 3'd1,
    LK_RUN   = 3'd2,
    LK_DOWN  = 3'd3,
    LK_TEST  = 3'd4
  } lk_mode_t;

  // index of the last bit of slot 2, counted from frame start
  function automatic int slot2_last(int slot0_bits, int slot_bits);
    return slot0_bits + 2 * slot_bits - 1;
  endfunction

  // counter width able to hold values 0..n
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/aclk_bitdiv.sv
module aclk_bitdiv #(
  parameter int FRAME_BITS = 256,
  parameter int S2_LAST    = 55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  input  logic run,
  input  logic sync_rise,
  output logic ph,
  output logic slot2_end
);
  localparam int PW = $clog2(FRAME_BITS);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n || !div_en) ph <= 1'b0;
    else                   ph <= ~ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || sync_rise) pos <= '0;
    else if (ph)                     pos <= (pos == PW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
  end

  assign slot2_end = run && ph && (pos == PW'(S2_LAST));
endmodule

// File: rtl/aclk_syncmeter.sv
module aclk_syncmeter #(
  parameter int WARM_MIN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic sync,
  output logic sync_rise,
  output logic warm_hit
);
  localparam int WW = aclk_pkg::cnt_width(WARM_MIN);

  logic          sync_q;
  logic [WW-1:0] wid;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || !sync) wid <= '0;
    else if (wid != WW'(WARM_MIN)) wid <= wid + 1'b1;
  end

  assign sync_rise = sync && !sync_q;
  assign warm_hit  = armed && !sync && (wid == WW'(WARM_MIN));
endmodule

// File: rtl/aclk_seq.sv
module aclk_seq
  import aclk_pkg::*;
#(
  parameter int START_DLY = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sdata_out,
  input  logic     pd_cmd,
  input  logic     slot2_end,
  input  logic     warm_hit,
  output lk_mode_t mode
);
  localparam int CW = cnt_width(START_DLY);

  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= LK_COLD;
      cnt  <= '0;
    end else begin
      unique case (mode)
        LK_COLD: begin
          cnt  <= '0;
          mode <= sdata_out ? LK_TEST : LK_START;
        end
        LK_START: begin
          if (cnt == CW'(START_DLY - 1)) mode <= LK_RUN;
          else                           cnt  <= cnt + 1'b1;
        end
        LK_RUN:  if (slot2_end && (pend || pd_cmd)) mode <= LK_DOWN;
        LK_DOWN: begin
          cnt <= '0;
          if (warm_hit) mode <= LK_START;
        end
        default: mode <= LK_TEST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode != LK_RUN) pend <= 1'b0;
    else                          pend <= pend || pd_cmd;
  end
endmodule

// File: rtl/aclink_pwr_ctl.sv
module aclink_pwr_ctl
  import aclk_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT0_BITS = 16,
  parameter int SLOT_BITS  = 20,
  parameter int START_DLY  = 4,
  parameter int WARM_MIN   = 24
) (
  input  logic mclk,
  input  logic rst_pin_n,
  input  logic sync,
  input  logic sdata_out,
  input  logic pd_cmd,
  output logic bit_clk,
  output logic bit_clk_en,
  output logic div_en,
  output logic sdin_en,
  output logic pad_oe,
  output logic regs_rst
);
  localparam int S2_LAST = slot2_last(SLOT0_BITS, SLOT_BITS);

  lk_mode_t mode;
  logic     ph;
  logic     slot2_end;
  logic     sync_rise;
  logic     warm_hit;
  logic     running;
  logic     armed;

  assign running = (mode == LK_RUN);
  assign armed   = (mode == LK_DOWN);

  aclk_seq #(.START_DLY(START_DLY)) u_seq (
    .clk(mclk), .rst_n(rst_pin_n), .sdata_out(sdata_out), .pd_cmd(pd_cmd),
    .slot2_end(slot2_end), .warm_hit(warm_hit), .mode(mode)
  );

  aclk_bitdiv #(.FRAME_BITS(FRAME_BITS), .S2_LAST(S2_LAST)) u_div (
    .clk(mclk), .rst_n(rst_pin_n), .div_en(div_en), .run(running),
    .sync_rise(sync_rise), .ph(ph), .slot2_end(slot2_end)
  );

  aclk_syncmeter #(.WARM_MIN(WARM_MIN)) u_meter (
    .clk(mclk), .rst_n(rst_pin_n), .armed(armed), .sync(sync),
    .sync_rise(sync_rise), .warm_hit(warm_hit)
  );

  assign div_en     = (mode == LK_START) || running;
  assign bit_clk_en = running;
  assign bit_clk    = running && ph;
  assign sdin_en    = running;
  assign pad_oe     = (mode != LK_TEST);
  assign regs_rst   = (mode == LK_COLD);
endmodule

// File: rtl/aclk_chk.sv
module aclk_chk (
  input logic mclk,
  input logic rst_pin_n,
  input logic bit_clk,
  input logic bit_clk_en,
  input logic div_en,
  input logic sdin_en,
  input logic pad_oe,
  input logic regs_rst,
  input logic slot2_end,
  input logic warm_hit
);
  AST_COLD_STATE: assert property (@(posedge mclk) !rst_pin_n |=> (regs_rst && pad_oe && !bit_clk_en && !div_en && !sdin_en)); // R1
  AST_HALF_RATE: assert property (@(posedge mclk) disable iff (!rst_pin_n) (bit_clk_en && $past(bit_clk_en)) |-> (bit_clk != $past(bit_clk))); // R3
  AST_STOP_AT_SLOT2: assert property (@(posedge mclk) disable iff (!rst_pin_n) $fell(bit_clk_en) |-> $past(slot2_end)); // R5
  AST_WAKE_QUALIFIED: assert property (@(posedge mclk) disable iff (!rst_pin_n) ($rose(div_en) && !$past(regs_rst)) |-> $past(warm_hit)); // R7
  AST_TEST_QUIET: assert property (@(posedge mclk) disable iff (!rst_pin_n) !pad_oe |-> (!bit_clk_en && !div_en && !sdin_en && !regs_rst)); // R9
endmodule

bind aclink_pwr_ctl aclk_chk u_chk (
  .mclk(mclk), .rst_pin_n(rst_pin_n), .bit_clk(bit_clk), .bit_clk_en(bit_clk_en),
  .div_en(div_en), .sdin_en(sdin_en), .pad_oe(pad_oe), .regs_rst(regs_rst),
  .slot2_end(slot2_end), .warm_hit(warm_hit)
);

// File: tb/sim_aclink_pwr_ctl.sv
`timescale 1ns/1ps
module sim_aclink_pwr_ctl;
  localparam int FB = 256, S0 = 16, SW = 20, SD = 4, WM = 24;
  localparam int S2 = S0 + 2 * SW - 1;

  logic mclk = 1'b0;
  logic rst_pin_n = 1'b0, sync = 1'b0, sdata_out = 1'b0, pd_cmd = 1'b0;
  logic bit_clk, bit_clk_en, div_en, sdin_en, pad_oe, regs_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 mclk = ~mclk;

  aclink_pwr_ctl #(.FRAME_BITS(FB), .SLOT0_BITS(S0), .SLOT_BITS(SW),
                   .START_DLY(SD), .WARM_MIN(WM)) u0 (
    .mclk(mclk), .rst_pin_n(rst_pin_n), .sync(sync), .sdata_out(sdata_out),
    .pd_cmd(pd_cmd), .bit_clk(bit_clk), .bit_clk_en(bit_clk_en), .div_en(div_en),
    .sdin_en(sdin_en), .pad_oe(pad_oe), .regs_rst(regs_rst)
  );

  // behavioural reference: 0 cold, 1 startup, 2 running, 3 stopped, 4 test
  int m_mode = 0, m_cnt = 0, m_pos = 0, m_w = 0;
  bit m_ph = 0, m_pend = 0, m_syncq = 0, rise, started = 0;

  always @(posedge mclk) begin
    if (!rst_pin_n) begin
      m_mode = 0; m_cnt = 0; m_ph = 0; m_pos = 0; m_pend = 0; m_w = 0; m_syncq = 0;
    end else begin
      rise = sync && !m_syncq;
      case (m_mode)
        0: if (sdata_out) m_mode = 4; else begin m_mode = 1; m_cnt = 0; m_ph = 0; end
        1: begin
          m_ph = !m_ph;
          if (m_cnt == SD - 1) begin m_mode = 2; m_pos = 0; m_pend = 0; end
          else m_cnt++;
        end
        2: begin
          if (m_pos == S2 && m_ph && (m_pend || pd_cmd)) begin m_mode = 3; m_ph = 0; m_w = 0; end
          else begin
            m_pend = m_pend || pd_cmd;
            if (rise) m_pos = 0; else if (m_ph) m_pos = (m_pos + 1) % FB;
            m_ph = !m_ph;
          end
        end
        3: begin
          if (sync) begin if (m_w < WM) m_w++; end
          else begin
            if (m_w >= WM) begin m_mode = 1; m_cnt = 0; m_ph = 0; end
            m_w = 0;
          end
        end
        default: ;
      endcase
      m_syncq = sync;
    end
    started = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge mclk) if (started && !done) begin
    check(regs_rst == (m_mode == 0), "R1 regs_rst", regs_rst, m_mode == 0);
    check(div_en == (m_mode == 1 || m_mode == 2), "R2 div_en", div_en, m_mode == 1 || m_mode == 2);
    check(bit_clk == (m_mode == 2 && m_ph), "R3 bit_clk", bit_clk, m_mode == 2 && m_ph);
    check(bit_clk_en == (m_mode == 2), "R5 bit_clk_en", bit_clk_en, m_mode == 2);
    check(sdin_en == (m_mode == 2), "R5 sdin_en", sdin_en, m_mode == 2);
    check(pad_oe == (m_mode != 4), "R9 pad_oe", pad_oe, m_mode != 4);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic release_count(output int n);
    n = 0;
    @(negedge mclk) rst_pin_n = 1'b1;
    do begin @(negedge mclk); n++; end while (!bit_clk_en && n < 50);
  endtask

  task automatic sync_pulse(input int len);
    @(negedge mclk) sync = 1'b1;
    wait_n(len);
    sync = 1'b0;
  endtask

  initial begin
    int n, highs, tog;
    bit prev;
    wait_n(4);
    check(regs_rst && pad_oe && !bit_clk_en && !div_en && !bit_clk, "R1 cold state", regs_rst, 1);

    release_count(n);
    check(n == SD + 1, "R2 startup delay", n, SD + 1);

    prev = bit_clk; tog = 0;
    for (int i = 0; i < 8; i++) begin @(negedge mclk); if (bit_clk != prev) tog++; prev = bit_clk; end
    check(tog == 8, "R3 half rate toggles", tog, 8);

    sync_pulse(40); wait_n(3);
    check(bit_clk_en == 1'b1, "R4 long sync while running", bit_clk_en, 1);

    // power-down issued at frame start: stop after bit S2
    wait_n(7);
    @(negedge mclk) begin sync = 1'b1; pd_cmd = 1'b1; end
    highs = 0;
    for (int i = 1; i < 2000 && bit_clk_en !== 1'b0; i++) begin
      @(negedge mclk);
      if (bit_clk_en && bit_clk) highs++;
      if (i == 1) pd_cmd = 1'b0;
      if (i == 32) sync = 1'b0;
    end
    sync = 1'b0;
    check(highs == S2 + 1, "R5 bits before stop", highs, S2 + 1);

    @(negedge mclk) pd_cmd = 1'b1;
    @(negedge mclk) pd_cmd = 1'b0;
    sync_pulse(WM - 1); wait_n(20);
    check(!div_en && !bit_clk_en, "R6 short pulse ignored", div_en, 0);

    sync_pulse(WM);
    n = 0;
    do begin @(negedge mclk); n++; end while (!bit_clk_en && n < 50);
    check(n == SD + 1, "R7 warm wake delay", n, SD + 1);

    // late command: waits for next frame's slot 2
    sync_pulse(32); wait_n(200);
    @(negedge mclk) pd_cmd = 1'b1;
    @(negedge mclk) pd_cmd = 1'b0;
    wait_n(150);
    check(bit_clk_en == 1'b1, "R5 late command not early", bit_clk_en, 1);
    wait_n(600);
    check(bit_clk_en == 1'b0, "R5 late command stops", bit_clk_en, 0);

    @(negedge mclk) rst_pin_n = 1'b0;
    wait_n(3);
    check(regs_rst == 1'b1, "R8 cold reset from stopped", regs_rst, 1);
    release_count(n);
    check(n == SD + 1, "R8 restart after cold reset", n, SD + 1);
    wait_n(100);
    @(negedge mclk) pd_cmd = 1'b1;
    @(negedge mclk) begin pd_cmd = 1'b0; rst_pin_n = 1'b0; end
    wait_n(3);
    release_count(n);
    wait_n(700);
    check(bit_clk_en == 1'b1, "R8 pending cleared", bit_clk_en, 1);

    @(negedge mclk) begin rst_pin_n = 1'b0; sdata_out = 1'b1; end
    wait_n(3);
    @(negedge mclk) rst_pin_n = 1'b1;
    @(negedge mclk) sdata_out = 1'b0;
    wait_n(2);
    check(pad_oe == 1'b0, "R9 test state entered", pad_oe, 0);
    sync_pulse(WM + 6);
    @(negedge mclk) pd_cmd = 1'b1;
    @(negedge mclk) pd_cmd = 1'b0;
    wait_n(20);
    check(!pad_oe && !div_en && !regs_rst, "R9 test state holds", pad_oe, 0);
    @(negedge mclk) rst_pin_n = 1'b0;
    wait_n(3);
    release_count(n);
    check(pad_oe && n == SD + 1, "R9 exit by cold reset", n, SD + 1);

    wait_n(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule